// File: doc/BRIEF.md
# Status Register Masked-Write Unit

This block holds a 32-bit processor status word and a saved copy of it. It applies move-to-status writes to them. Each write chooses one of the two registers as its target. It chooses the bits to change in one of two forms. In byte-field form, four select bits each enable one byte lane. In application-flag form, two select bits each enable one flag group. The source value is either a 32-bit register operand or a 12-bit encoded immediate, which the block expands itself.

The privilege mode is the 5-bit mode field held in the low bits of the current register. In unprivileged (user) mode, only the condition/saturation flags and the four greater-or-equal flags of the current register can change. Every other selected bit keeps its value, so user code cannot leave user mode. The user and system modes have no saved register. A write aimed at the saved copy from either of them is refused and reported on a one-cycle illegal-access output. Writes that reach the condition-flag bits raise a one-cycle flag-update pulse.

Top module: `psr_write_unit`

## Requirements
- R1: After synchronous active-low reset, the current register reads 0x000000D3 (supervisor mode 5'b10011 in bits [4:0], both interrupt masks bits [7:6] set, all flags clear), the saved register reads 0, and both pulse outputs are low.
- R2: In byte-field form (`flag_form`=0), `field_sel[0]` writes bits [7:0], `field_sel[1]` bits [15:8], `field_sel[2]` bits [23:16] and `field_sel[3]` bits [31:24]. Bits in unselected lanes keep their previous values.
- R3: In application-flag form (`flag_form`=1), `grp_sel[1]` writes only bits [31:27] and `grp_sel[0]` writes only bits [19:16]. `field_sel` is ignored.
- R4: While the current mode bits [4:0] equal 5'b10000 (user), a write to the current register changes at most bits [31:27] and [19:16], whatever the selects say, so the mode field cannot change.
- R5: A write aimed at the saved register while the mode is 5'b10000 or 5'b11111 (system) leaves both registers unchanged. `illegal_acc` is high for exactly the one cycle after that edge.
- R6: From any other mode, a write aimed at the saved register applies the same field rules as R2/R3 with no user restriction, and leaves the current register unchanged.
- R7: With `use_imm`=1, the operand is `imm12[7:0]` zero-extended and rotated right by 2×`imm12[11:8]` positions. A rotate field of 0 gives the plain zero-extended value.
- R8: An update becomes visible after the rising edge that samples `wr_en` high. While `wr_en` is low, neither register changes, whatever the other inputs are.
- R9: `flags_wr` is high for exactly the one cycle after an edge that applied a write to the current register whose effective mask includes any of bits [31:27].
- R10: In system mode (5'b11111), writes to the current register are unrestricted, like any other privileged mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_saved | input | 1 | Target: 1 = saved register, 0 = current register |
| flag_form | input | 1 | 1 = application-flag groups, 0 = byte fields |
| field_sel | input | 4 | Byte-lane selects, bit n enables bits [8n+7:8n] |
| grp_sel | input | 2 | Flag-group selects: [1] bits [31:27], [0] bits [19:16] |
| use_imm | input | 1 | 1 = operand from encoded immediate |
| imm12 | input | 12 | Rotate amount [11:8], value [7:0] |
| src_data | input | 32 | Register operand |
| cur_psr | output | 32 | Current status register |
| saved_psr | output | 32 | Saved status register |
| flags_wr | output | 1 | One-cycle pulse: condition flags were written |
| illegal_acc | output | 1 | One-cycle pulse: saved register access refused |

## Verification
The hardest cases to reach are those that depend on the mode: user-mode protection and the refused saved-register access. The block always leaves reset in supervisor mode, and the only way into user or system mode is a privileged write that changes its own control byte. Each table vector therefore resets the block, loads the saved copy while still privileged, and then loads the wanted current value (mode included) with a full four-lane write. Only after that does it apply the write under test. Directed steps then check the pulse widths, the cycle at which an update appears, and that idle cycles with random inputs change nothing.

// File: rtl/psr_pkg.sv
// Package: shared constants and mode encodings for the status register unit.
// Assumes a 32-bit status word with the mode in bits [4:0].
package psr_pkg;

    localparam int PSR_W   = 32;
    localparam int MODE_W  = 5;
    localparam int LANE_W  = 8;
    localparam int LANES   = PSR_W / LANE_W;
    localparam int IMM_VW  = 8;
    localparam int IMM_RW  = 4;
    localparam int IMM_W   = IMM_VW + IMM_RW;

    // Processor mode encodings held in the low bits of the current register.
    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } psr_mode_e;

    // Condition and saturation flag group, bits [31:27].
    localparam logic [PSR_W-1:0] GRP_COND_MASK = 32'hF800_0000;
    // Greater-or-equal flag group, bits [19:16].
    localparam logic [PSR_W-1:0] GRP_GE_MASK   = 32'h000F_0000;
    // Bits that unprivileged code may change in the current register.
    localparam logic [PSR_W-1:0] USER_WR_MASK  = GRP_COND_MASK | GRP_GE_MASK;
    // Reset: supervisor mode, IRQ and FIQ masked, flags clear.
    localparam logic [PSR_W-1:0] PSR_RESET     = 32'h0000_00D3;

endpackage

// File: rtl/psr_imm_expand.sv
// Immediate expander: turns a rotate/value pair into a full-width operand.
// Assumes the rotate field counts pairs of bit positions (rotate right by 2*rot).
module psr_imm_expand #(
    parameter int DATA_W = 32,
    parameter int VAL_W  = 8,
    parameter int ROT_W  = 4,
    localparam int ENC_W = VAL_W + ROT_W,
    localparam int AMT_W = ROT_W + 1
) (
    input  logic [ENC_W-1:0]  enc,
    output logic [DATA_W-1:0] value
);

    logic [DATA_W-1:0]   zext;
    logic [AMT_W-1:0]    amount;
    logic [2*DATA_W-1:0] doubled;

    // Split the encoding into the zero-extended value and the shift amount.
    always_comb begin
        zext   = {{(DATA_W-VAL_W){1'b0}}, enc[VAL_W-1:0]};
        amount = {enc[ENC_W-1:VAL_W], 1'b0};
    end

    // Rotate right by shifting a doubled copy and keeping the low half.
    always_comb begin
        doubled = {zext, zext} >> amount;
        value   = doubled[DATA_W-1:0];
    end

    // A rotation never changes the number of set bits.
    always_comb begin
        AST_IMM_POPCOUNT: assert ($countones(value) == $countones(enc[VAL_W-1:0])); // R7
    end

endmodule

// File: rtl/psr_mode_decode.sv
// Mode decoder: classifies the mode field of the current register.
// Assumes user and system modes are the only ones without a saved register.
module psr_mode_decode
    import psr_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output logic              is_user,
    output logic              no_saved
);

    // Compare the mode field against the two special encodings.
    always_comb begin
        is_user  = (mode == MODE_USR);
        no_saved = (mode == MODE_USR) || (mode == MODE_SYS);
    end

endmodule

// File: rtl/psr_mask_gen.sv
// Mask generator: builds the per-bit write enable from the lane or group selects,
// then clips it to the user-writable bits when the write is unprivileged.
// Assumes a 32-bit word; group positions come from the package.
module psr_mask_gen
    import psr_pkg::*;
#(
    parameter int DATA_W  = PSR_W,
    parameter int LANE_BW = LANE_W,
    localparam int NLANES = DATA_W / LANE_BW
) (
    input  logic              flag_form,
    input  logic [NLANES-1:0] lane_sel,
    input  logic [1:0]        grp_sel,
    input  logic              restrict_user,
    output logic [DATA_W-1:0] mask
);

    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] grp_mask;
    logic [DATA_W-1:0] raw_mask;

    // One replicated enable per byte lane.
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        always_comb lane_mask[g*LANE_BW +: LANE_BW] = {LANE_BW{lane_sel[g]}};
    end

    // Combine the two flag groups that the flag form may select.
    always_comb begin
        grp_mask = '0;
        if (grp_sel[1]) grp_mask = grp_mask | GRP_COND_MASK[DATA_W-1:0];
        if (grp_sel[0]) grp_mask = grp_mask | GRP_GE_MASK[DATA_W-1:0];
    end

    // Choose the form, then clip to the user-writable bits.
    always_comb begin
        raw_mask = flag_form ? grp_mask : lane_mask;
        mask     = restrict_user ? (raw_mask & USER_WR_MASK[DATA_W-1:0]) : raw_mask;
    end

endmodule

// File: rtl/psr_bank.sv
// Register bank: holds the current and saved status words and the two
// one-cycle indications. Assumes the mask is already clipped for privilege.
module psr_bank
    import psr_pkg::*;
#(
    parameter int DATA_W = PSR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_saved,
    input  logic              no_saved,
    input  logic [DATA_W-1:0] wr_mask,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cur_q,
    output logic [DATA_W-1:0] sav_q,
    output logic              flag_pulse_q,
    output logic              illegal_q
);

    logic              cur_we;
    logic              sav_we;
    logic              refused;
    logic              cond_hit;
    logic [DATA_W-1:0] cur_next;
    logic [DATA_W-1:0] sav_next;

    // Decide which register the write lands in and what is refused.
    always_comb begin
        cur_we   = wr_en && !wr_saved;
        refused  = wr_en && wr_saved && no_saved;
        sav_we   = wr_en && wr_saved && !no_saved;
        cond_hit = |(wr_mask & GRP_COND_MASK[DATA_W-1:0]);
    end

    // Merge new data into the selected bits, keep the rest.
    always_comb begin
        cur_next = (cur_q & ~wr_mask) | (wr_data & wr_mask);
        sav_next = (sav_q & ~wr_mask) | (wr_data & wr_mask);
    end

    // Current register and flag-update pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q        <= PSR_RESET[DATA_W-1:0];
            flag_pulse_q <= 1'b0;
        end else begin
            flag_pulse_q <= cur_we && cond_hit;
            if (cur_we) cur_q <= cur_next;
        end
    end

    // Saved register and refused-access pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sav_q     <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= refused;
            if (sav_we) sav_q <= sav_next;
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(cur_q) && $stable(sav_q))); // R8
    AST_SAVED_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_saved && no_saved) |=> ($stable(sav_q) && illegal_q)); // R5
    AST_SAVED_CUR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_saved) |=> $stable(cur_q)); // R6
    AST_USER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q[MODE_W-1:0] == MODE_USR) |=>
        ((cur_q & ~USER_WR_MASK[DATA_W-1:0]) == ($past(cur_q) & ~USER_WR_MASK[DATA_W-1:0]))); // R4
    AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> $past(wr_en && wr_saved)); // R5
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_pulse_q |-> $past(wr_en && !wr_saved)); // R9

endmodule

// File: rtl/psr_write_unit.sv
// Top: status register masked-write unit. Selects the operand, derives the
// privilege class from the current mode field, builds the write mask and
// updates the bank. Assumes one write per cycle at most.
module psr_write_unit
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_saved,
    input  logic              flag_form,
    input  logic [LANES-1:0]  field_sel,
    input  logic [1:0]        grp_sel,
    input  logic              use_imm,
    input  logic [IMM_W-1:0]  imm12,
    input  logic [PSR_W-1:0]  src_data,
    output logic [PSR_W-1:0]  cur_psr,
    output logic [PSR_W-1:0]  saved_psr,
    output logic              flags_wr,
    output logic              illegal_acc
);

    logic [PSR_W-1:0] imm_value;
    logic [PSR_W-1:0] operand;
    logic [PSR_W-1:0] eff_mask;
    logic             is_user;
    logic             no_saved;
    logic             restrict_user;

    psr_imm_expand #(
        .DATA_W (PSR_W),
        .VAL_W  (IMM_VW),
        .ROT_W  (IMM_RW)
    ) i_imm (
        .enc   (imm12),
        .value (imm_value)
    );

    psr_mode_decode i_mode (
        .mode     (cur_psr[MODE_W-1:0]),
        .is_user  (is_user),
        .no_saved (no_saved)
    );

    // Pick the operand and decide whether user clipping applies.
    always_comb begin
        operand       = use_imm ? imm_value : src_data;
        restrict_user = is_user && !wr_saved;
    end

    psr_mask_gen #(
        .DATA_W  (PSR_W),
        .LANE_BW (LANE_W)
    ) i_mask (
        .flag_form     (flag_form),
        .lane_sel      (field_sel),
        .grp_sel       (grp_sel),
        .restrict_user (restrict_user),
        .mask          (eff_mask)
    );

    psr_bank #(
        .DATA_W (PSR_W)
    ) i_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_saved     (wr_saved),
        .no_saved     (no_saved),
        .wr_mask      (eff_mask),
        .wr_data      (operand),
        .cur_q        (cur_psr),
        .sav_q        (saved_psr),
        .flag_pulse_q (flags_wr),
        .illegal_q    (illegal_acc)
    );

endmodule

// File: tb/test_psr_write_unit.sv
`timescale 1ns/1ps
module test_psr_write_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_saved, flag_form, use_imm;
    logic [3:0]  field_sel;
    logic [1:0]  grp_sel;
    logic [11:0] imm12;
    logic [31:0] src_data;
    logic [31:0] cur_psr, saved_psr;
    logic        flags_wr, illegal_acc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    psr_write_unit i_psr_write_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_saved(wr_saved),
        .flag_form(flag_form), .field_sel(field_sel), .grp_sel(grp_sel),
        .use_imm(use_imm), .imm12(imm12), .src_data(src_data),
        .cur_psr(cur_psr), .saved_psr(saved_psr),
        .flags_wr(flags_wr), .illegal_acc(illegal_acc)
    );

    typedef struct packed {
        logic [31:0] pre_cur;
        logic [31:0] pre_sav;
        logic        sel_sav;
        logic        ff;
        logic [3:0]  fm;
        logic [1:0]  gm;
        logic        ui;
        logic [11:0] imm;
        logic [31:0] src;
        logic [31:0] exp_cur;
        logic [31:0] exp_sav;
        logic        exp_flag;
        logic        exp_ill;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        // R2: status lane only
        '{32'h000000D3, 32'h0, 1'b0, 1'b0, 4'b0100, 2'b00, 1'b0, 12'h0, 32'hAABBCCDD, 32'h00BB00D3, 32'h0, 1'b0, 1'b0, 8'd2},
        // R2: flags and control lanes, R9 flag pulse
        '{32'h000000D3, 32'h0, 1'b0, 1'b0, 4'b1001, 2'b00, 1'b0, 12'h0, 32'h12345678, 32'h12000078, 32'h0, 1'b1, 1'b0, 8'd2},
        // R3: condition group only
        '{32'h000000D3, 32'h0, 1'b0, 1'b1, 4'b1111, 2'b10, 1'b0, 12'h0, 32'hFFFFFFFF, 32'hF80000D3, 32'h0, 1'b1, 1'b0, 8'd3},
        // R3: GE group only
        '{32'h000000D3, 32'h0, 1'b0, 1'b1, 4'b1111, 2'b01, 1'b0, 12'h0, 32'hFFFFFFFF, 32'h000F00D3, 32'h0, 1'b0, 1'b0, 8'd3},
        // R4: user full write clipped
        '{32'h00000010, 32'h0, 1'b0, 1'b0, 4'b1111, 2'b00, 1'b0, 12'h0, 32'hFFFFFFFF, 32'hF80F0010, 32'h0, 1'b1, 1'b0, 8'd4},
        // R4: user attempt to change mode
        '{32'h00000010, 32'h0, 1'b0, 1'b0, 4'b0001, 2'b00, 1'b0, 12'h0, 32'h000000D3, 32'h00000010, 32'h0, 1'b0, 1'b0, 8'd4},
        // R5: saved target from user
        '{32'h00000010, 32'h11111111, 1'b1, 1'b0, 4'b1111, 2'b00, 1'b0, 12'h0, 32'h0, 32'h00000010, 32'h11111111, 1'b0, 1'b1, 8'd5},
        // R5: saved target from system
        '{32'h0000001F, 32'h22222222, 1'b1, 1'b0, 4'b1111, 2'b00, 1'b0, 12'h0, 32'h0, 32'h0000001F, 32'h22222222, 1'b0, 1'b1, 8'd5},
        // R6: saved target from supervisor
        '{32'h000000D3, 32'h0, 1'b1, 1'b0, 4'b0011, 2'b00, 1'b0, 12'h0, 32'hCAFEBABE, 32'h000000D3, 32'h0000BABE, 1'b0, 1'b0, 8'd6},
        // R7: rotate 4 -> right by 8
        '{32'h000000D3, 32'h0, 1'b0, 1'b0, 4'b1111, 2'b00, 1'b1, 12'h4FF, 32'h0, 32'hFF000000, 32'h0, 1'b1, 1'b0, 8'd7},
        // R7: rotate 0 zero-extends
        '{32'h000000D3, 32'h0, 1'b0, 1'b0, 4'b0001, 2'b00, 1'b1, 12'h0AB, 32'hFFFFFFFF, 32'h000000AB, 32'h0, 1'b0, 1'b0, 8'd7},
        // R7: rotate 1 -> right by 2
        '{32'h000000D3, 32'h0, 1'b0, 1'b0, 4'b1111, 2'b00, 1'b1, 12'h13C, 32'h0, 32'h0000000F, 32'h0, 1'b1, 1'b0, 8'd7},
        // R7: rotate 15 -> right by 30
        '{32'h000000D3, 32'h0, 1'b0, 1'b0, 4'b0011, 2'b00, 1'b1, 12'hF81, 32'h0, 32'h00000204, 32'h0, 1'b0, 1'b0, 8'd7},
        // R10: system writes all lanes
        '{32'h0000001F, 32'h0, 1'b0, 1'b0, 4'b1111, 2'b00, 1'b0, 12'h0, 32'h12345613, 32'h12345613, 32'h0, 1'b1, 1'b0, 8'd10},
        // R4: user flag form both groups
        '{32'h00000010, 32'h0, 1'b0, 1'b1, 4'b0000, 2'b11, 1'b0, 12'h0, 32'hFFFFFFFF, 32'hF80F0010, 32'h0, 1'b1, 1'b0, 8'd4}
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_saved = 1'b0; flag_form = 1'b0;
        field_sel = '0; grp_sel = '0; use_imm = 1'b0; imm12 = '0; src_data = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Drive one write at a falling edge; returns at the next falling edge.
    task automatic apply(input logic sv, input logic ff, input logic [3:0] fm, input logic [1:0] gm,
                         input logic ui, input logic [11:0] imm, input logic [31:0] src);
        @(negedge clk);
        wr_en = 1'b1; wr_saved = sv; flag_form = ff; field_sel = fm;
        grp_sel = gm; use_imm = ui; imm12 = imm; src_data = src;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        // R1: reset state
        do_reset();
        check("R1", "cur", cur_psr, 32'h000000D3);
        check("R1", "saved", saved_psr, 32'h0);
        check("R1", "flags_wr", {31'b0, flags_wr}, 32'h0);
        check("R1", "illegal", {31'b0, illegal_acc}, 32'h0);

        // Table walk: reset, preload saved then current, apply the write under test.
        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VEC[i].req);
            do_reset();
            apply(1'b1, 1'b0, 4'hF, 2'b00, 1'b0, 12'h0, VEC[i].pre_sav);
            apply(1'b0, 1'b0, 4'hF, 2'b00, 1'b0, 12'h0, VEC[i].pre_cur);
            apply(VEC[i].sel_sav, VEC[i].ff, VEC[i].fm, VEC[i].gm, VEC[i].ui, VEC[i].imm, VEC[i].src);
            check(rq, $sformatf("vec%0d cur", i), cur_psr, VEC[i].exp_cur);
            check(rq, $sformatf("vec%0d saved", i), saved_psr, VEC[i].exp_sav);
            check(rq, $sformatf("vec%0d flags_wr", i), {31'b0, flags_wr}, {31'b0, VEC[i].exp_flag});
            check(rq, $sformatf("vec%0d illegal", i), {31'b0, illegal_acc}, {31'b0, VEC[i].exp_ill});
        end

        // R8: nothing visible before the sampling edge, visible after it.
        do_reset();
        @(negedge clk);
        wr_en = 1'b1; wr_saved = 1'b0; flag_form = 1'b0; field_sel = 4'hF; src_data = 32'hFFFFFFFF;
        #1;
        check("R8", "before edge", cur_psr, 32'h000000D3);
        @(negedge clk);
        wr_en = 1'b0;
        check("R8", "after edge", cur_psr, 32'hFFFFFFFF);
        // R8: idle cycles with busy inputs change nothing.
        wr_saved = 1'b1; field_sel = 4'hF; src_data = 32'h0; use_imm = 1'b1; imm12 = 12'h3AA;
        repeat (3) @(negedge clk);
        check("R8", "idle cur", cur_psr, 32'hFFFFFFFF);
        check("R8", "idle saved", saved_psr, 32'h0);

        // R9: flag pulse lasts one cycle.
        do_reset();
        apply(1'b0, 1'b1, 4'h0, 2'b10, 1'b0, 12'h0, 32'h80000000);
        check("R9", "pulse high", {31'b0, flags_wr}, 32'h1);
        @(negedge clk);
        check("R9", "pulse low", {31'b0, flags_wr}, 32'h0);

        // R5: refused access pulse lasts one cycle, in system mode.
        do_reset();
        apply(1'b0, 1'b0, 4'h1, 2'b00, 1'b0, 12'h0, 32'h0000001F);
        apply(1'b1, 1'b0, 4'hF, 2'b00, 1'b0, 12'h0, 32'h55555555);
        check("R5", "illegal high", {31'b0, illegal_acc}, 32'h1);
        @(negedge clk);
        check("R5", "illegal low", {31'b0, illegal_acc}, 32'h0);
        check("R5", "saved kept", saved_psr, 32'h0);

        // R4: user cannot return to supervisor through the control lane.
        do_reset();
        apply(1'b0, 1'b0, 4'h1, 2'b00, 1'b0, 12'h0, 32'h00000010);
        apply(1'b0, 1'b0, 4'hF, 2'b00, 1'b1, 12'h0D3, 32'h0);
        check("R4", "mode kept", cur_psr, 32'h00000010);

        report();
    end

endmodule